// File: doc/BRIEF.md
# SDRAM write burst sequencer

This block is the device-side write path of a synchronous DRAM. It watches the command pins on every rising clock edge, recognises a WRITE, and from that edge onward stores one data word per clock into a small internal array. The bank and starting column are latched with the command. Each later column address is generated inside the block, for a fixed burst of 1, 2, 4 or 8 words or for a full-page burst that runs until something stops it.

The word on the command edge is the first word of the burst. A new WRITE may arrive on any edge. It cuts off the running burst, and its data on that edge belongs to the new burst. Any other command stops a running burst. When the WRITE carried the auto-precharge bit, a one-cycle request tagged with the bank follows the last word. A truncated burst never raises that request.

Burst length and full-page mode are configuration inputs, sampled with each WRITE. A combinational read port exposes the array, so that the surrounding logic, or a bench, can inspect what was stored.

Top module: `sdram_wr_burst`

## Requirements
- R1: A WRITE is decoded only when cke_i=1, cs_ni=0, ras_ni=1, cas_ni=0 and we_ni=0. Any other pin state writes nothing to the array, and that includes any state with cke_i=0.
- R2: On the WRITE edge, dq_i is stored at (ba_i, col_i) when dqm_i is low.
- R3: With full_page_i=0, blen_i codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 words. The column counts up by one per edge and wraps inside the aligned block whose size is the burst length.
- R4: After the last word of a fixed burst, further edges carrying NOP or deselect leave the array unchanged, whatever is on dq_i.
- R5: With full_page_i=1, the burst never ends by itself. After the top column it continues from column 0.
- R6: A WRITE on any edge of a running burst ends that burst. The data on that edge is stored at the new bank and column.
- R7: A data edge with dqm_i=1 stores nothing, and the column still advances.
- R8: When the WRITE had ap_i=1, prech_req_o is high for exactly the cycle after the burst's last word, and prech_bank_o gives that burst's bank. With ap_i=0, or for a burst truncated by a new WRITE, no request is raised.
- R9: While a burst is running, a command with cs_ni=0 other than WRITE or NOP (ras_ni=cas_ni=we_ni=1) ends the burst and stores nothing. An edge with cs_ni=1 continues the burst like a NOP.
- R10: burst_o is high after an edge exactly when more words of the current burst are still due.
- R11: After reset the array reads all zero, and burst_o and prech_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_i | input | 1 | Clock enable; low freezes the sequencer |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | BANK_W | Bank address |
| col_i | input | COL_W | Starting column |
| ap_i | input | 1 | Auto-precharge select, sampled with WRITE |
| dq_i | input | DQ_W | Write data |
| dqm_i | input | 1 | Data mask, high suppresses the word |
| blen_i | input | 2 | Fixed burst length code (1, 2, 4, 8) |
| full_page_i | input | 1 | Full-page burst select |
| rd_bank_i | input | BANK_W | Read port bank |
| rd_col_i | input | COL_W | Read port column |
| rd_data_o | output | DQ_W | Array word at the read address |
| burst_o | output | 1 | Burst words still due |
| prech_req_o | output | 1 | Auto-precharge request pulse |
| prech_bank_o | output | BANK_W | Bank of the precharge request |

## Verification
The assertions take for granted that blen_i and full_page_i are stable whenever they are sampled with a WRITE. They also assume that the read port is used only as an observer and never steers the write path. The stimulus drives every pin half a cycle away from the sampling edge. It changes the configuration inputs only together with a WRITE, and it reads the array only while no burst is running, so every stored word can be compared against a model built from the requirements.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  typedef enum logic [1:0] {BL1 = 2'd0, BL2 = 2'd1, BL4 = 2'd2, BL8 = 2'd3} blen_e;
  typedef enum logic [1:0] {CMD_HOLD, CMD_NOP, CMD_WRITE, CMD_OTHER} cmd_e;
endpackage

// File: rtl/wrb_cmd_dec.sv
module wrb_cmd_dec
  import wrb_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (!cke_i)     cmd_o = CMD_HOLD;
    else if (cs_ni) cmd_o = CMD_NOP;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b100:  cmd_o = CMD_WRITE;
        default: cmd_o = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/wrb_col_gen.sv
module wrb_col_gen
  import wrb_pkg::*;
#(
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [COL_W-1:0] col_i,
  input  blen_e            blen_i,
  input  logic             full_i,
  output logic [COL_W-1:0] col_o,
  output logic             word_o,
  output logic             last_o,
  output logic             active_o
);
  localparam int CNT_W = 4;

  logic             active_q, full_q;
  logic [COL_W-1:0] col_q, mask_q;
  logic [CNT_W-1:0] cnt_q;

  logic             start, cont, cur_full;
  logic [COL_W-1:0] cur_mask, nxt_col;
  logic [CNT_W-1:0] rem;

  function automatic logic [COL_W-1:0] mask_of(blen_e b);
    return COL_W'((8'd1 << b) - 8'd1);
  endfunction

  assign start    = (cmd_i == CMD_WRITE);
  assign cont     = active_q && (cmd_i == CMD_NOP);
  assign word_o   = start || cont;
  assign col_o    = start ? col_i : col_q;
  assign cur_mask = start ? mask_of(blen_i) : mask_q;
  assign cur_full = start ? full_i : full_q;
  // words still due, the current one included
  assign rem      = start ? (CNT_W'(1) << blen_i) : cnt_q;
  assign last_o   = word_o && !cur_full && (rem == CNT_W'(1));
  assign active_o = active_q;

  always_comb begin
    if (cur_full) nxt_col = col_o + COL_W'(1);
    else          nxt_col = (col_o & ~cur_mask) | ((col_o + COL_W'(1)) & cur_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      col_q    <= '0;
      mask_q   <= '0;
      cnt_q    <= '0;
    end else if (word_o) begin
      col_q    <= nxt_col;
      mask_q   <= cur_mask;
      full_q   <= cur_full;
      cnt_q    <= rem - CNT_W'(1);
      active_q <= cur_full || (rem != CNT_W'(1));
    end else if (active_q && cmd_i == CMD_OTHER) begin
      active_q <= 1'b0;
    end
  end

  p_fixed_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !full_q && cmd_i == CMD_NOP)
      |=> ((col_q & ~mask_q) == $past(col_q & ~mask_q)));

  p_stop_after_last_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !full_q && cnt_q == CNT_W'(1) && cmd_i == CMD_NOP) |=> !active_q);

  p_page_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && full_q && cmd_i == CMD_NOP && col_q == '1) |=> (col_q == '0));

  p_other_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cmd_i == CMD_OTHER) |=> !active_q);
endmodule

// File: rtl/wrb_mem_array.sv
module wrb_mem_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  p_write_lands_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst
  import wrb_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 4,
  parameter int DQ_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_i,
  input  logic              cs_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic              ap_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic              dqm_i,
  input  logic [1:0]        blen_i,
  input  logic              full_page_i,
  input  logic [BANK_W-1:0] rd_bank_i,
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [DQ_W-1:0]   rd_data_o,
  output logic              burst_o,
  output logic              prech_req_o,
  output logic [BANK_W-1:0] prech_bank_o
);
  localparam int AW = BANK_W + COL_W;

  cmd_e             cmd;
  logic [COL_W-1:0] cur_col;
  logic             word, last, start;
  logic [BANK_W-1:0] bank_q, cur_bank;
  logic             ap_q, cur_ap;
  logic             pre_q;
  logic [BANK_W-1:0] pre_bank_q;

  wrb_cmd_dec u_dec (
    .cke_i (cke_i),
    .cs_ni (cs_ni),
    .ras_ni(ras_ni),
    .cas_ni(cas_ni),
    .we_ni (we_ni),
    .cmd_o (cmd)
  );

  wrb_col_gen #(.COL_W(COL_W)) u_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd),
    .col_i   (col_i),
    .blen_i  (blen_e'(blen_i)),
    .full_i  (full_page_i),
    .col_o   (cur_col),
    .word_o  (word),
    .last_o  (last),
    .active_o(burst_o)
  );

  assign start    = (cmd == CMD_WRITE);
  assign cur_bank = start ? ba_i : bank_q;
  assign cur_ap   = start ? ap_i : ap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q     <= '0;
      ap_q       <= 1'b0;
      pre_q      <= 1'b0;
      pre_bank_q <= '0;
    end else begin
      if (start) begin
        bank_q <= ba_i;
        ap_q   <= ap_i;
      end
      pre_q <= last && cur_ap;
      if (last) pre_bank_q <= cur_bank;
    end
  end

  assign prech_req_o  = pre_q;
  assign prech_bank_o = pre_bank_q;

  wrb_mem_array #(.AW(AW), .DW(DQ_W)) u_mem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (word && !dqm_i),
    .waddr_i({cur_bank, cur_col}),
    .wdata_i(dq_i),
    .raddr_i({rd_bank_i, rd_col_i}),
    .rdata_o(rd_data_o)
  );

  p_pre_follows_word_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prech_req_o |-> $past(word));

  p_no_pre_while_due_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prech_req_o |-> !(burst_o && !$past(start)));

  p_hold_freezes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd == CMD_HOLD) |=> $stable(burst_o));
endmodule

// File: tb/sim_sdram_wr_burst.sv
module sim_sdram_wr_burst;
  localparam int BANK_W = 2, COL_W = 4, DQ_W = 16;
  localparam int NB = 1 << BANK_W, NC = 1 << COL_W;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
  logic [BANK_W-1:0] ba_i = '0, rd_bank_i = '0, prech_bank_o;
  logic [COL_W-1:0]  col_i = '0, rd_col_i = '0;
  logic ap_i = 1'b0, dqm_i = 1'b0, full_page_i = 1'b0;
  logic [DQ_W-1:0] dq_i = '0, rd_data_o;
  logic [1:0] blen_i = 2'd0;
  logic burst_o, prech_req_o;

  sdram_wr_burst #(.BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .col_i(col_i), .ap_i(ap_i),
    .dq_i(dq_i), .dqm_i(dqm_i), .blen_i(blen_i), .full_page_i(full_page_i),
    .rd_bank_i(rd_bank_i), .rd_col_i(rd_col_i), .rd_data_o(rd_data_o),
    .burst_o(burst_o), .prech_req_o(prech_req_o), .prech_bank_o(prech_bank_o)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [DQ_W-1:0] ref_mem [NB][NC];
  bit m_act, m_full, m_ap;
  int m_bank, m_col, m_cnt, m_mask;

  typedef struct packed { logic pre; logic [BANK_W-1:0] bank; logic busy; } exp_t;
  exp_t exp_q[$];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R10 burst_o", 32'(burst_o), 32'(e.busy));
      chk("R8 prech_req_o", 32'(prech_req_o), 32'(e.pre));
      if (e.pre) chk("R8 prech_bank_o", 32'(prech_bank_o), 32'(e.bank));
    end
  end

  function automatic int nxt(int c, int mask, bit full);
    if (full) return (c + 1) % NC;
    return (c & ~mask) | ((c + 1) & mask);
  endfunction

  // driver: one clock with the given pins, model update, expected item pushed
  task automatic step(bit k, bit cs, bit r, bit c, bit w, int ba, int col, bit ap,
                      int dq, bit dqm, int bl, bit fp);
    exp_t e;
    bit is_wr, is_nop, pre;
    int pb;
    cke_i = k; cs_ni = cs; ras_ni = r; cas_ni = c; we_ni = w;
    ba_i = BANK_W'(ba); col_i = COL_W'(col); ap_i = ap; dq_i = DQ_W'(dq);
    dqm_i = dqm; blen_i = 2'(bl); full_page_i = fp;
    @(posedge clk);
    is_wr  = k && !cs && r && !c && !w;
    is_nop = cs || (r && c && w);
    pre = 1'b0; pb = 0;
    if (!k) begin
    end else if (is_wr) begin
      if (!dqm) ref_mem[ba][col] = DQ_W'(dq);
      m_bank = ba; m_ap = ap; m_full = fp; m_mask = (1 << bl) - 1;
      m_cnt = (1 << bl) - 1;
      m_col = nxt(col, m_mask, fp);
      m_act = fp || (m_cnt > 0);
      if (!m_act && ap) begin pre = 1'b1; pb = ba; end
    end else if (m_act) begin
      if (!is_nop) m_act = 1'b0;
      else begin
        if (!dqm) ref_mem[m_bank][m_col] = DQ_W'(dq);
        m_col = nxt(m_col, m_mask, m_full);
        if (!m_full) begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_act = 1'b0;
            if (m_ap) begin pre = 1'b1; pb = m_bank; end
          end
        end
      end
    end
    e.pre = pre; e.bank = BANK_W'(pb); e.busy = m_act;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic wr(int ba, int col, bit ap, int dq, int bl, bit fp, bit dqm = 0);
    step(1, 0, 1, 0, 0, ba, col, ap, dq, dqm, bl, fp);
  endtask
  task automatic nop(int dq, bit dqm = 0);
    step(1, 0, 1, 1, 1, 0, 0, 0, dq, dqm, blen_i, full_page_i);
  endtask
  task automatic desel(int dq);
    step(1, 1, 0, 0, 0, 0, 0, 0, dq, 0, blen_i, full_page_i);
  endtask

  task automatic sweep(string req);
    for (int b = 0; b < NB; b++)
      for (int c = 0; c < NC; c++) begin
        rd_bank_i = BANK_W'(b); rd_col_i = COL_W'(c);
        #1;
        chk(req, 32'(rd_data_o), 32'(ref_mem[b][c]));
      end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++)
      for (int c = 0; c < NC; c++) ref_mem[b][c] = '0;
    m_act = 0; m_full = 0; m_ap = 0; m_bank = 0; m_col = 0; m_cnt = 0; m_mask = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 burst_o", 32'(burst_o), 0);
    chk("R11 prech_req_o", 32'(prech_req_o), 0);
    sweep("R11 array");

    // R3 length 4 from column 6 wraps inside 4..7; R4 extra data ignored; R9 deselect continues
    wr(1, 6, 1, 'h1006, 2, 0);
    nop('h1007);
    desel('h1004);
    nop('h1005);
    nop('hdead); nop('hbeef); desel('hcafe);
    sweep("R3 R4 fixed burst");

    // R7 mask in a length-8 burst, ap low: no request (R8)
    wr(2, 3, 0, 'h2003, 3, 0);
    nop('h2004); nop('hffff, 1); nop('h2006); nop('h2007);
    nop('h2000); nop('hffff, 1); nop('h2002);
    nop('h9999);
    sweep("R7 masked words");

    // R2 R6 back-to-back single words with precharge pulses
    wr(0, 0, 1, 'h3000, 0, 0);
    wr(3, 9, 1, 'h3309, 0, 0);
    wr(1, 15, 0, 'h3115, 0, 0);
    wr(2, 12, 1, 'h3212, 0, 0);
    nop('h7777); nop('h7777);
    sweep("R2 back-to-back");

    // R6 truncation: length 4 burst cut by a new WRITE to another bank, no request for the first
    wr(0, 8, 1, 'h4008, 2, 0);
    nop('h4009);
    wr(3, 2, 1, 'h4302, 1, 0);
    nop('h4303);
    nop('h5555);
    sweep("R6 truncation");

    // R1 non-WRITE codes and clock-enable low do nothing
    step(1, 0, 1, 0, 1, 2, 5, 0, 'haaaa, 0, 0, 0);
    step(0, 0, 1, 0, 0, 2, 6, 0, 'hbbbb, 0, 0, 0);
    step(1, 0, 0, 1, 1, 2, 7, 0, 'hcccc, 0, 0, 0);
    sweep("R1 decode");

    // R5 full page from column 13, wraps past 15, then R9 other command ends it
    wr(3, 13, 1, 'h5000, 0, 1);
    for (int i = 1; i < 20; i++) nop('h5000 + i);
    step(1, 0, 0, 1, 0, 0, 0, 0, 'h6666, 0, 0, 1);
    nop('h6667); nop('h6668);
    sweep("R5 R9 full page");

    // R1 clock enable low mid-burst holds, then burst resumes
    wr(1, 0, 1, 'h7000, 1, 0);
    step(0, 0, 1, 1, 1, 0, 0, 0, 'h7fff, 0, 1, 0);
    nop('h7001);
    nop('h7002);
    sweep("R1 hold");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule